// File: doc/BRIEF.md
# Chroma U/V Gain Interpolator

This block takes a chroma stream in which U and V samples share one data path, one sample per pixel slot, each marked by a component flag. Every accepted sample is passed through a fixed chain. First a 3-tap [1,2,1]/4 low-pass filter runs on that component's own history. Next comes a first 2x interpolation: a midpoint is inserted between the previous filtered sample of the same component and the new one. Then a gain is applied, chosen by the component flag. Last comes a second 2x interpolation, which inserts midpoints between the gained samples of the same component. Each input sample therefore gives four output samples, so the output runs at four times the sample rate and is ready for a modulator. The component flag travels with the data, so the gain chosen and the output tag always match the sample being produced.

A small state machine controls the timing. The states are ST_IDLE (no output), then ST_PH0, ST_PH1, ST_PH2 and ST_PH3 (the four output slots of one input sample). The transitions are:
- accept: ST_IDLE or ST_PH3 goes to ST_PH0 when `in_valid` is high.
- advance: ST_PH0 goes to ST_PH1, ST_PH1 goes to ST_PH2, and ST_PH2 goes to ST_PH3, one step per cycle.
- drain: ST_PH3 goes to ST_IDLE when `in_valid` is low.

Top module: `chroma_uv_interp`

## Requirements
- R1: When reset is asserted, `out_valid` is 0, and all per-component filter and interpolation histories are cleared to zero. The first U sample after reset, with value 40 and gain 128, therefore produces the outputs 2, 5, 7, 10.
- R2: The filtered value is f = floor((x + 2·x1 + x2)/4). Here x1 and x2 are the two previous accepted inputs of the same component.
- R3: The first interpolation forms m = floor((fp + f)/2), where fp is the previous filtered value of the same component. The gain stage then receives m followed by f.
- R4: Gain is an unsigned 8-bit value with 7 fraction bits, so 128 means unity. A sample with `in_is_v`=0 is scaled by `gain_u` and a sample with `in_is_v`=1 by `gain_v`, as y = floor(x·g/128).
- R5: Each gained value is saturated to the signed 10-bit range [-512, 511].
- R6: Take a sample accepted at clock edge E. Let ha and hb be its gained values and hp the last hb of the same component. Then `out_valid` is 1 for the four cycles after E, and `out_data` shows floor((hp+ha)/2), ha, floor((ha+hb)/2) and hb in that order.
- R7: `out_is_v` equals the accepted sample's `in_is_v` during all four of its output cycles.
- R8: `in_valid` is ignored in ST_PH0, ST_PH1 and ST_PH2. It is accepted in ST_PH3, which gives back-to-back bursts with no idle cycle.
- R9: U and V histories never mix. A U sample's result depends only on earlier U samples, and a V sample's result only on earlier V samples.
- R10: The gains are sampled at the accept edge. Changing `gain_u` or `gain_v` during a burst does not alter that burst's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_is_v | input | 1 | Component flag: 0 = U, 1 = V |
| in_data | input | 10 | Signed chroma sample |
| gain_u | input | 8 | U gain, 1.7 unsigned |
| gain_v | input | 8 | V gain, 1.7 unsigned |
| out_valid | output | 1 | Output sample strobe |
| out_is_v | output | 1 | Component tag of the output sample |
| out_data | output | 10 | Signed scaled, interpolated chroma |

## Verification
The table drives strictly alternating U/V samples with differing gains, including zero, unity and above-unity gains, and negative data. A swapped gain selection or a crossed component history shows up there at once. A run of one component alone, from reset, separates filter weights and interpolation midpoints by giving known hand-computed values. Full-scale positive and negative steady inputs at maximum gain expose a missing or misplaced clip. Back-to-back bursts, and junk strobes with changed gains during a burst, tell whether the accept window and the gain sampling edge are placed correctly.

// File: rtl/chroma_pkg.sv
package chroma_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PH0,
        ST_PH1,
        ST_PH2,
        ST_PH3
    } phase_e;

    localparam int NUM_COMP = 2;
endpackage

// File: rtl/chroma_lpf.sv
module chroma_lpf #(
    parameter int W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                comp,
    input  logic signed [W-1:0] x,
    output logic signed [W-1:0] y
);
    import chroma_pkg::*;
    localparam int SW = W + 2;

    logic signed [W-1:0] h1 [NUM_COMP];
    logic signed [W-1:0] h2 [NUM_COMP];
    logic signed [SW-1:0] acc;

    for (genvar c = 0; c < NUM_COMP; c++) begin : g_comp
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                h1[c] <= '0;
                h2[c] <= '0;
            end else if (load && comp == 1'(c)) begin
                h2[c] <= h1[c];
                h1[c] <= x;
            end
        end

        // R9: a sample of the other component leaves this history untouched
        assert_no_mix_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (load && comp != 1'(c)) |=> ($stable(h1[c]) && $stable(h2[c])));
    end

    always_comb begin
        acc = SW'(x) + (SW'(h1[comp]) <<< 1) + SW'(h2[comp]);
        y   = acc[SW-1:2];
    end
endmodule

// File: rtl/chroma_hist.sv
module chroma_hist #(
    parameter int W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                comp,
    input  logic signed [W-1:0] d,
    output logic signed [W-1:0] q
);
    import chroma_pkg::*;

    logic signed [W-1:0] mem [NUM_COMP];

    for (genvar c = 0; c < NUM_COMP; c++) begin : g_comp
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[c] <= '0;
            else if (load && comp == 1'(c))
                mem[c] <= d;
        end
    end

    assign q = mem[comp];
endmodule

// File: rtl/chroma_gain.sv
module chroma_gain #(
    parameter int W  = 10,
    parameter int GW = 8,
    parameter int GF = 7
) (
    input  logic signed [W-1:0] x,
    input  logic        [GW-1:0] gain,
    output logic signed [W-1:0] y
);
    localparam int PW = W + GW + 1;
    localparam logic signed [PW-1:0] MAXV = PW'((1 <<< (W - 1)) - 1);
    localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);
    localparam logic [GW-1:0] UNITY = GW'(1 <<< GF);

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] scaled;

    always_comb begin
        prod   = PW'(x) * $signed(PW'({1'b0, gain}));
        scaled = prod >>> GF;
        if (scaled > MAXV)
            y = MAXV[W-1:0];
        else if (scaled < MINV)
            y = MINV[W-1:0];
        else
            y = scaled[W-1:0];
    end

    // R4: a unity gain passes the sample through unchanged
    always_comb begin
        if (gain == UNITY)
            assert_unity_gain_R4: assert (y == x);
    end
endmodule

// File: rtl/chroma_uv_interp.sv
module chroma_uv_interp #(
    parameter int DATA_W = 10,
    parameter int GAIN_W = 8,
    parameter int GAIN_F = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     in_is_v,
    input  logic signed [DATA_W-1:0] in_data,
    input  logic        [GAIN_W-1:0] gain_u,
    input  logic        [GAIN_W-1:0] gain_v,
    output logic                     out_valid,
    output logic                     out_is_v,
    output logic signed [DATA_W-1:0] out_data
);
    import chroma_pkg::*;
    localparam int MW = DATA_W + 1;

    phase_e state, state_nx;
    logic accept;
    logic signed [DATA_W-1:0] f_cur, f_prev, mid1, h_a, h_b, h_prev;
    logic signed [DATA_W-1:0] mid_a, mid_b;
    logic signed [MW-1:0] sum1, sum_a, sum_b;
    logic [GAIN_W-1:0] gain_sel;
    logic signed [DATA_W-1:0] r_s0, r_s1, r_s2, r_s3;
    logic r_tag;

    assign accept   = in_valid && (state == ST_IDLE || state == ST_PH3);
    assign gain_sel = in_is_v ? gain_v : gain_u;

    chroma_lpf #(.W(DATA_W)) u_lpf (
        .clk(clk), .rst_n(rst_n), .load(accept), .comp(in_is_v),
        .x(in_data), .y(f_cur)
    );

    chroma_hist #(.W(DATA_W)) u_fhist (
        .clk(clk), .rst_n(rst_n), .load(accept), .comp(in_is_v),
        .d(f_cur), .q(f_prev)
    );

    chroma_hist #(.W(DATA_W)) u_hhist (
        .clk(clk), .rst_n(rst_n), .load(accept), .comp(in_is_v),
        .d(h_b), .q(h_prev)
    );

    always_comb begin
        sum1 = MW'(f_prev) + MW'(f_cur);
        mid1 = sum1[MW-1:1];
    end

    chroma_gain #(.W(DATA_W), .GW(GAIN_W), .GF(GAIN_F)) u_gain_mid (
        .x(mid1), .gain(gain_sel), .y(h_a)
    );

    chroma_gain #(.W(DATA_W), .GW(GAIN_W), .GF(GAIN_F)) u_gain_cur (
        .x(f_cur), .gain(gain_sel), .y(h_b)
    );

    always_comb begin
        sum_a = MW'(h_prev) + MW'(h_a);
        sum_b = MW'(h_a) + MW'(h_b);
        mid_a = sum_a[MW-1:1];
        mid_b = sum_b[MW-1:1];
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (accept) state_nx = ST_PH0;
            ST_PH0:  state_nx = ST_PH1;
            ST_PH1:  state_nx = ST_PH2;
            ST_PH2:  state_nx = ST_PH3;
            ST_PH3:  state_nx = accept ? ST_PH0 : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_s0  <= '0;
            r_s1  <= '0;
            r_s2  <= '0;
            r_s3  <= '0;
            r_tag <= 1'b0;
        end else if (accept) begin
            r_s0  <= mid_a;
            r_s1  <= h_a;
            r_s2  <= mid_b;
            r_s3  <= h_b;
            r_tag <= in_is_v;
        end
    end

    always_comb begin
        out_valid = 1'b0;
        out_data  = '0;
        unique case (state)
            ST_IDLE: ;
            ST_PH0:  begin out_valid = 1'b1; out_data = r_s0; end
            ST_PH1:  begin out_valid = 1'b1; out_data = r_s1; end
            ST_PH2:  begin out_valid = 1'b1; out_data = r_s2; end
            ST_PH3:  begin out_valid = 1'b1; out_data = r_s3; end
            default: ;
        endcase
        out_is_v = r_tag;
    end

    assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state inside {ST_PH0, ST_PH1, ST_PH2}) |=> ($stable(out_is_v) && $stable(r_s3)));

    assert_burst_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state inside {ST_PH0, ST_PH1, ST_PH2}) |=> out_valid);

    assert_tag_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && in_valid) |=> (out_valid && out_is_v == $past(in_is_v)));
endmodule

// File: tb/chroma_uv_interp_bench.sv
module chroma_uv_interp_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_is_v = 1'b0;
    logic signed [9:0] in_data = '0;
    logic [7:0] gain_u = 8'd128;
    logic [7:0] gain_v = 8'd128;
    logic out_valid;
    logic out_is_v;
    logic signed [9:0] out_data;

    int n_chk = 0;
    int n_err = 0;
    int m_x1 [2];
    int m_x2 [2];
    int m_fp [2];
    int m_hp [2];
    int e [4];

    always #5 clk = ~clk;

    chroma_uv_interp u_chroma_uv_interp (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_is_v(in_is_v),
        .in_data(in_data), .gain_u(gain_u), .gain_v(gain_v),
        .out_valid(out_valid), .out_is_v(out_is_v), .out_data(out_data)
    );

    typedef struct packed {
        logic              v;
        logic signed [9:0] d;
        logic [7:0]        gu;
        logic [7:0]        gv;
        logic              b2b;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{1'b0,  10'sd200, 8'd128, 8'd64,  1'b0},
        '{1'b1,  10'sd200, 8'd128, 8'd64,  1'b0},
        '{1'b0, -10'sd150, 8'd200, 8'd255, 1'b1},
        '{1'b1,  10'sd300, 8'd200, 8'd255, 1'b1},
        '{1'b0,  10'sd511, 8'd255, 8'd0,   1'b0},
        '{1'b1, -10'sd512, 8'd255, 8'd0,   1'b1},
        '{1'b0,  10'sd511, 8'd255, 8'd32,  1'b0},
        '{1'b1, -10'sd300, 8'd96,  8'd160, 1'b1},
        '{1'b0, -10'sd7,   8'd1,   8'd128, 1'b0},
        '{1'b1,  10'sd77,  8'd129, 8'd127, 1'b0},
        '{1'b1,  10'sd77,  8'd129, 8'd127, 1'b1},
        '{1'b0,  10'sd0,   8'd128, 8'd128, 1'b0}
    };

    function automatic int sat10(input int v);
        if (v > 511) return 511;
        if (v < -512) return -512;
        return v;
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            m_x1[c] = 0; m_x2[c] = 0; m_fp[c] = 0; m_hp[c] = 0;
        end
    endtask

    // expected outputs from R2..R6 with per-component history (R9)
    task automatic model_step(input int c, input int x, input int g);
        int f, m, ha, hb;
        f  = (x + 2 * m_x1[c] + m_x2[c]) >>> 2;
        m  = (m_fp[c] + f) >>> 1;
        ha = sat10((m * g) >>> 7);
        hb = sat10((f * g) >>> 7);
        e[0] = (m_hp[c] + ha) >>> 1;
        e[1] = ha;
        e[2] = (ha + hb) >>> 1;
        e[3] = hb;
        m_x2[c] = m_x1[c]; m_x1[c] = x; m_fp[c] = f; m_hp[c] = hb;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // send one sample; junk=1 drives ignored strobes with other gains (R8, R10)
    task automatic send(input bit v, input int d, input int gu, input int gv,
                        input bit b2b, input bit junk);
        if (!b2b) @(negedge clk);
        in_valid = 1'b1; in_is_v = v; in_data = 10'(d);
        gain_u = 8'(gu); gain_v = 8'(gv);
        model_step(int'(v), d, v ? gv : gu);
        @(negedge clk);
        if (junk) begin
            in_valid = 1'b1; in_is_v = ~v; in_data = 10'sd333;
            gain_u = 8'd7; gain_v = 8'd250;
        end else
            in_valid = 1'b0;
        chk("R6 valid slot0", int'(out_valid), 1);
        chk("R7 tag", int'(out_is_v), int'(v));
        chk("R6 slot0 R3", int'(out_data), e[0]);
        @(negedge clk);
        chk("R6 slot1 R4", int'(out_data), e[1]);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R6 slot2 R10", int'(out_data), e[2]);
        @(negedge clk);
        chk("R6 slot3 R2 R5", int'(out_data), e[3]);
        chk("R7 tag held R8", int'(out_is_v), int'(v));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        model_reset();
        do_reset();
        chk("R1 idle after reset", int'(out_valid), 0);

        // R1: first U sample after reset, hand values 2,5,7,10
        send(1'b0, 40, 128, 128, 1'b0, 1'b0);
        chk("R1 hand slot3", int'(out_data), 10);
        @(negedge clk);
        chk("R6 drain to idle", int'(out_valid), 0);

        for (int i = 0; i < NV; i++)
            send(VEC[i].v, int'(VEC[i].d), int'(VEC[i].gu), int'(VEC[i].gv),
                 VEC[i].b2b, 1'b0);

        // R8 / R10: junk strobes and gain changes during a burst
        send(1'b1, 123, 90, 140, 1'b0, 1'b1);
        send(1'b0, -60, 140, 90, 1'b0, 1'b1);
        send(1'b1, 5, 128, 128, 1'b1, 1'b0);

        // R9: interleaved V must not enter U filter: U f = (100+200)/4 = 75
        do_reset();
        send(1'b0, 100, 128, 128, 1'b0, 1'b0);
        send(1'b1, 400, 128, 128, 1'b0, 1'b0);
        send(1'b0, 100, 128, 128, 1'b1, 1'b0);
        chk("R9 U isolated", int'(out_data), 75);

        // R5: steady full scale with gain 255 clips both ways
        do_reset();
        for (int k = 0; k < 3; k++) begin
            send(1'b0, 511, 255, 255, 1'b0, 1'b0);
            send(1'b1, -512, 255, 255, 1'b1, 1'b0);
        end
        chk("R5 negative clip", int'(out_data), -512);
        send(1'b0, 511, 255, 255, 1'b1, 1'b0);
        chk("R5 positive clip", int'(out_data), 511);

        // R1: reset in mid burst
        @(negedge clk);
        in_valid = 1'b1; in_is_v = 1'b0; in_data = 10'sd50;
        @(negedge clk);
        in_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset mid burst", int'(out_valid), 0);
        rst_n = 1'b1;
        model_reset();
        send(1'b0, 40, 128, 128, 1'b0, 1'b0);
        chk("R1 history cleared", int'(out_data), 10);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule